// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit load/store processor that completes one instruction on every clock edge. In each cycle it presents the program counter on the instruction port and decodes the returned word. It then reads two operands from a 32-entry register file and computes a result, an effective address or a new program counter. The result is written back at the closing edge. Instruction memory and data memory sit outside the core as plain word arrays. The core reads both combinationally and writes data memory at the clock edge when its write strobe is high.

The supported instructions are:
- Register-type: add, sub, and, or, set-less-than, the three constant shifts, the three register-controlled shifts and the register jump.
- Immediate-type: add-immediate, or-immediate, load-upper, word load, word store, the two compare branches and the absolute jump.

Two status outputs report problems, each as a one-cycle pulse in the cycle after the offending instruction. The first reports signed overflow of an add or subtract. The second reports a word load or store whose address is not word aligned. The faulting instruction leaves no architectural effect. An opcode or function code outside the supported set behaves as a no-op.

Top module: `onecyc_core`

## Requirements
- R1: While `rst` is high at a clock edge the program counter is set to 0x00400000. In the first cycle after reset is released, `imem_addr` is 0x00400000 and both flags are low.
- R2: An instruction that is not a branch or jump advances `imem_addr` by 4 at the next edge. The redirecting opcodes are 000100 (branch if equal), 000101 (branch if not equal) and 000010 (jump), plus register-type function 001000 (register jump).
- R3: Register 0 reads as zero, and any write to it is discarded.
- R4: Register-type words have opcode 000000 and the fields rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. Function codes 100000 (add), 100010 (subtract), 100100 (and), 100101 (or) and 101010 (signed set-less-than, result 1 or 0) write rs op rt into rd.
- R5: Opcode 001000 adds the sign-extended imm[15:0] to rs and writes rt. When add-immediate, add or subtract overflows in two's complement, the destination is left unchanged and `ovf_flag` pulses high in the next cycle.
- R6: Opcode 001101 writes rt with rs OR the zero-extended immediate. Opcode 001111 writes rt with the immediate in bits 31:16 and zeros in bits 15:0.
- R7: Functions 000000, 000010 and 000011 shift rt left logical, right logical and right arithmetic by shamt, writing rd. Functions 000100, 000110 and 000111 do the same, taking the amount from rs[4:0] instead.
- R8: Opcode 100011 loads the word at rs + sign-extended imm into rt. Opcode 101011 stores rt to that address.
- R9: A load or store whose address has bits [1:0] not both zero neither writes memory nor updates the destination register, and `misalign_flag` pulses high in the next cycle.
- R10: A taken branch jumps to PC+4 plus the sign-extended immediate shifted left by 2. Branch-if-equal is taken when rs equals rt, branch-if-not-equal when they differ, and an untaken branch goes to PC+4.
- R11: The jump goes to {PC+4 bits 31:28, instr[25:0], 00}, and the register jump loads rs into the program counter.
- R12: Each flag is high for exactly one cycle per faulting instruction, in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Program counter, byte address of the instruction fetched this cycle |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, the word is written at the clock edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| ovf_flag | output | 1 | Signed overflow pulse for the previous instruction |
| misalign_flag | output | 1 | Misaligned access pulse for the previous instruction |

## Verification
A wrong program counter shows on `imem_addr` at the very next edge, so sequencing, branch and jump faults are caught within one cycle. A corrupted register stays hidden until a store places it on `dmem_wdata`. For that reason every scenario stores its results to data memory, and the bench compares the memory after the program settles in a self-loop. Flag faults are visible one cycle after the offending instruction, and the bench ties each pulse to the program counter of the instruction before it.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_JMP   = 6'b000010;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LUI   = 6'b001111;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;

  localparam logic [5:0] FN_SLL  = 6'b000000;
  localparam logic [5:0] FN_SRL  = 6'b000010;
  localparam logic [5:0] FN_SRA  = 6'b000011;
  localparam logic [5:0] FN_SLLV = 6'b000100;
  localparam logic [5:0] FN_SRLV = 6'b000110;
  localparam logic [5:0] FN_SRAV = 6'b000111;
  localparam logic [5:0] FN_JR   = 6'b001000;
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_SLT  = 6'b101010;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_UPPER
  } alu_op_t;

  typedef struct packed {
    alu_op_t alu_op;
    logic    b_imm;
    logic    imm_zext;
    logic    sh_var;
    logic    wr_en;
    logic    dst_rd;
    logic    mem_rd;
    logic    mem_wr;
    logic    br_eq;
    logic    br_ne;
    logic    jmp;
    logic    jreg;
    logic    ovf_chk;
  } ctrl_t;

endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.wr_en  = 1'b1;
        case (funct)
          FN_ADD:  begin ctrl.alu_op = ALU_ADD; ctrl.ovf_chk = 1'b1; end
          FN_SUB:  begin ctrl.alu_op = ALU_SUB; ctrl.ovf_chk = 1'b1; end
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          FN_SLL:  ctrl.alu_op = ALU_SLL;
          FN_SRL:  ctrl.alu_op = ALU_SRL;
          FN_SRA:  ctrl.alu_op = ALU_SRA;
          FN_SLLV: begin ctrl.alu_op = ALU_SLL; ctrl.sh_var = 1'b1; end
          FN_SRLV: begin ctrl.alu_op = ALU_SRL; ctrl.sh_var = 1'b1; end
          FN_SRAV: begin ctrl.alu_op = ALU_SRA; ctrl.sh_var = 1'b1; end
          FN_JR:   begin ctrl.wr_en = 1'b0; ctrl.jreg = 1'b1; end
          default: ctrl.wr_en = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.b_imm = 1'b1; ctrl.wr_en = 1'b1; ctrl.ovf_chk = 1'b1;
      end
      OP_ORI: begin
        ctrl.alu_op = ALU_OR; ctrl.b_imm = 1'b1;
        ctrl.imm_zext = 1'b1; ctrl.wr_en = 1'b1;
      end
      OP_LUI: begin
        ctrl.alu_op = ALU_UPPER; ctrl.b_imm = 1'b1; ctrl.wr_en = 1'b1;
      end
      OP_LW: begin
        ctrl.b_imm = 1'b1; ctrl.mem_rd = 1'b1; ctrl.wr_en = 1'b1;
      end
      OP_SW: begin
        ctrl.b_imm = 1'b1; ctrl.mem_wr = 1'b1;
      end
      OP_BEQ: ctrl.br_eq = 1'b1;
      OP_BNE: ctrl.br_ne = 1'b1;
      OP_JMP: ctrl.jmp = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  alu_op_t        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SW-1:0]  shamt,
  output logic [W-1:0]   y,
  output logic           ovf
);

  localparam int HW = W / 2;

  logic [W-1:0] sum, diff;

  assign sum  = a + b;
  assign diff = a - b;

  always_comb begin
    y   = '0;
    ovf = 1'b0;
    case (op)
      ALU_ADD: begin
        y   = sum;
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      end
      ALU_SUB: begin
        y   = diff;
        ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
      end
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL:   y = b << shamt;
      ALU_SRL:   y = b >> shamt;
      ALU_SRA:   y = $unsigned($signed(b) >>> shamt);
      ALU_UPPER: y = {b[HW-1:0], {HW{1'b0}}};
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata
);

  logic [W-1:0] rf_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) rf_q[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : rf_q[raddr[p]];
  end

endmodule

// File: rtl/core_nextpc.sv
module core_nextpc #(
  parameter int W = 32
) (
  input  logic [W-1:0]  pc,
  input  logic [25:0]   jidx,
  input  logic [15:0]   imm,
  input  logic [W-1:0]  rs_val,
  input  logic          ops_equal,
  input  logic          br_eq,
  input  logic          br_ne,
  input  logic          jmp,
  input  logic          jreg,
  output logic [W-1:0]  pc_next
);

  localparam int EXT = W - 18;

  logic [W-1:0] pc4, br_tgt, j_tgt;
  logic         taken;

  assign pc4    = pc + W'(4);
  assign br_tgt = pc4 + {{EXT{imm[15]}}, imm, 2'b00};
  assign j_tgt  = {pc4[W-1:W-4], jidx, 2'b00};
  assign taken  = (br_eq && ops_equal) || (br_ne && !ops_equal);

  always_comb begin
    if (jreg)       pc_next = rs_val;
    else if (jmp)   pc_next = j_tgt;
    else if (taken) pc_next = br_tgt;
    else            pc_next = pc4;
  end

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
  import core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0040_0000,
  parameter int          NREGS    = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        ovf_flag,
  output logic        misalign_flag
);

  localparam int W  = 32;
  localparam int AW = $clog2(NREGS);
  localparam int SW = $clog2(W);

  logic [W-1:0] pc_q, pc_next;
  ctrl_t        ctrl;

  logic [5:0]  f_op, f_fn;
  logic [4:0]  f_rs, f_rt, f_rd, f_sh;
  logic [15:0] f_imm;

  assign f_op  = imem_rdata[31:26];
  assign f_rs  = imem_rdata[25:21];
  assign f_rt  = imem_rdata[20:16];
  assign f_rd  = imem_rdata[15:11];
  assign f_sh  = imem_rdata[10:6];
  assign f_fn  = imem_rdata[5:0];
  assign f_imm = imem_rdata[15:0];

  core_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  logic [1:0][AW-1:0] rf_raddr;
  logic [1:0][W-1:0]  rf_rdata;
  logic [W-1:0]       rs_val, rt_val, wb_data;
  logic [AW-1:0]      wb_addr;
  logic               wb_en;

  assign rf_raddr[0] = AW'(f_rs);
  assign rf_raddr[1] = AW'(f_rt);
  assign rs_val      = rf_rdata[0];
  assign rt_val      = rf_rdata[1];

  core_regfile #(.W(W), .DEPTH(NREGS), .NRD(2)) u_rf (
    .clk   (clk),
    .raddr (rf_raddr),
    .rdata (rf_rdata),
    .we    (wb_en),
    .waddr (wb_addr),
    .wdata (wb_data)
  );

  logic [W-1:0]  imm_ext, alu_b, alu_y;
  logic [SW-1:0] alu_sh;
  logic          alu_ovf;

  assign imm_ext = ctrl.imm_zext ? {16'h0000, f_imm} : {{16{f_imm[15]}}, f_imm};
  assign alu_b   = ctrl.b_imm ? imm_ext : rt_val;
  assign alu_sh  = ctrl.sh_var ? rs_val[SW-1:0] : f_sh;

  core_alu #(.W(W)) u_alu (
    .op    (ctrl.alu_op),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (alu_sh),
    .y     (alu_y),
    .ovf   (alu_ovf)
  );

  logic mem_acc, misaligned, ovf_hit;

  assign mem_acc    = ctrl.mem_rd || ctrl.mem_wr;
  assign misaligned = mem_acc && (alu_y[1:0] != 2'b00);
  assign ovf_hit    = ctrl.ovf_chk && alu_ovf;

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_wr && !misaligned && !rst;

  assign wb_data = ctrl.mem_rd ? dmem_rdata : alu_y;
  assign wb_addr = AW'(ctrl.dst_rd ? f_rd : f_rt);
  assign wb_en   = ctrl.wr_en && !ovf_hit && !(ctrl.mem_rd && misaligned) && !rst;

  core_nextpc #(.W(W)) u_npc (
    .pc        (pc_q),
    .jidx      (imem_rdata[25:0]),
    .imm       (f_imm),
    .rs_val    (rs_val),
    .ops_equal (rs_val == rt_val),
    .br_eq     (ctrl.br_eq),
    .br_ne     (ctrl.br_ne),
    .jmp       (ctrl.jmp),
    .jreg      (ctrl.jreg),
    .pc_next   (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q          <= RESET_PC;
      ovf_flag      <= 1'b0;
      misalign_flag <= 1'b0;
    end else begin
      pc_q          <= pc_next;
      ovf_flag      <= ovf_hit;
      misalign_flag <= misaligned;
    end
  end

  assign imem_addr = pc_q;

endmodule

// File: rtl/core_chk.sv
module core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic [1:0]  dmem_addr_lo,
  input logic        dmem_we,
  input logic [31:0] dmem_wdata,
  input logic        ovf_flag,
  input logic        misalign_flag
);

  logic [5:0]  c_op, c_fn;
  logic        is_rtype, redirects, ovf_kind, mem_kind, is_jump, rt_zero;
  logic [31:0] pc4_c, jtgt_c;

  assign c_op      = imem_rdata[31:26];
  assign c_fn      = imem_rdata[5:0];
  assign is_rtype  = (c_op == 6'b000000);
  assign is_jump   = (c_op == 6'b000010);
  assign redirects = is_jump || (c_op == 6'b000100) || (c_op == 6'b000101) ||
                     (is_rtype && c_fn == 6'b001000);
  assign ovf_kind  = (c_op == 6'b001000) ||
                     (is_rtype && (c_fn == 6'b100000 || c_fn == 6'b100010));
  assign mem_kind  = (c_op == 6'b100011) || (c_op == 6'b101011);
  assign rt_zero   = (imem_rdata[20:16] == 5'd0);
  assign pc4_c     = imem_addr + 32'd4;
  assign jtgt_c    = {pc4_c[31:28], imem_rdata[25:0], 2'b00};

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (imem_addr == RESET_PC) && !ovf_flag && !misalign_flag);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    !redirects |=> imem_addr == $past(pc4_c));

  assert_zero_store_R3: assert property (@(posedge clk) disable iff (rst)
    (dmem_we && rt_zero) |-> dmem_wdata == 32'd0);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> $past(ovf_kind));

  assert_aligned_store_R9: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> dmem_addr_lo == 2'b00);

  assert_jump_target_R11: assert property (@(posedge clk) disable iff (rst)
    is_jump |=> imem_addr == $past(jtgt_c));

  assert_misalign_src_R12: assert property (@(posedge clk) disable iff (rst)
    misalign_flag |-> $past(mem_kind));

endmodule

bind onecyc_core core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .imem_addr     (imem_addr),
  .imem_rdata    (imem_rdata),
  .dmem_addr_lo  (dmem_addr[1:0]),
  .dmem_we       (dmem_we),
  .dmem_wdata    (dmem_wdata),
  .ovf_flag      (ovf_flag),
  .misalign_flag (misalign_flag)
);

// File: tb/tb_onecyc_core.sv
module tb_onecyc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, ovf_flag, misalign_flag;

  logic [31:0] im [64];
  logic [31:0] dm [64];

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  int          ovf_cnt, mis_cnt;
  logic [31:0] ovf_pc, mis_pc, prev_pc;

  localparam logic [31:0] BASE = 32'h0040_0000;

  always #5 clk = ~clk;

  onecyc_core dut (
    .clk           (clk),
    .rst           (rst),
    .imem_addr     (imem_addr),
    .imem_rdata    (imem_rdata),
    .dmem_addr     (dmem_addr),
    .dmem_wdata    (dmem_wdata),
    .dmem_we       (dmem_we),
    .dmem_rdata    (dmem_rdata),
    .ovf_flag      (ovf_flag),
    .misalign_flag (misalign_flag)
  );

  assign imem_rdata = im[imem_addr[7:2]];
  assign dmem_rdata = dm[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

  always @(negedge clk) begin
    if (!rst) begin
      if (ovf_flag) begin
        ovf_cnt++;
        if (ovf_cnt == 1) ovf_pc = prev_pc;
      end
      if (misalign_flag) begin
        mis_cnt++;
        if (mis_cnt == 1) mis_pc = prev_pc;
      end
    end
    prev_pc = imem_addr;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  function automatic logic [31:0] fr(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] fi(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] fj(int idx);
    return {6'b000010, 26'(32'h0010_0000 + idx)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      im[i] = 32'h0;
      dm[i] = 32'h0;
    end
  endtask

  task automatic start(int cycles);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ovf_cnt = 0;
    mis_cnt = 0;
    ovf_pc  = 32'h0;
    mis_pc  = 32'h0;
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_mem();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 pc after reset", imem_addr, BASE);
    chk("R1 ovf flag idle", 32'(ovf_flag), 32'd0);
    chk("R1 misalign flag idle", 32'(misalign_flag), 32'd0);
    @(negedge clk);
    chk("R2 first step", imem_addr, BASE + 32'd4);
    @(negedge clk);
    chk("R2 second step", imem_addr, BASE + 32'd8);
  endtask

  task automatic t_arith();
    clear_mem();
    dm[8] = 32'hDEAD_BEEF;
    im[0]  = fi(6'b001000, 0, 3, 7);
    im[1]  = fi(6'b001000, 0, 4, 9);
    im[2]  = fr(3, 4, 5, 0, 6'b100000);
    im[3]  = fr(3, 4, 6, 0, 6'b100010);
    im[4]  = fr(3, 4, 7, 0, 6'b100100);
    im[5]  = fr(3, 4, 8, 0, 6'b100101);
    im[6]  = fr(6, 3, 9, 0, 6'b101010);
    im[7]  = fr(3, 6, 10, 0, 6'b101010);
    im[8]  = fi(6'b001000, 0, 11, 16'hFFFF);
    im[9]  = fi(6'b001000, 0, 0, 5);
    im[10] = fi(6'b101011, 0, 5, 4);
    im[11] = fi(6'b101011, 0, 6, 8);
    im[12] = fi(6'b101011, 0, 7, 12);
    im[13] = fi(6'b101011, 0, 8, 16);
    im[14] = fi(6'b101011, 0, 9, 20);
    im[15] = fi(6'b101011, 0, 10, 24);
    im[16] = fi(6'b101011, 0, 11, 28);
    im[17] = fi(6'b101011, 0, 0, 32);
    im[18] = fj(18);
    start(40);
    chk("R4 add 7+9", dm[1], 32'd16);
    chk("R4 sub 7-9", dm[2], 32'hFFFF_FFFE);
    chk("R4 and", dm[3], 32'd1);
    chk("R4 or", dm[4], 32'd15);
    chk("R4 slt signed true", dm[5], 32'd1);
    chk("R4 slt signed false", dm[6], 32'd0);
    chk("R5 addi sign extension", dm[7], 32'hFFFF_FFFF);
    chk("R3 register zero stays zero", dm[8], 32'd0);
    chk("R5 no overflow flag", 32'(ovf_cnt), 32'd0);
  endtask

  task automatic t_imm_shift();
    clear_mem();
    im[0]  = fi(6'b001111, 0, 1, 16'h8765);
    im[1]  = fi(6'b001101, 1, 1, 16'hF00F);
    im[2]  = fr(0, 1, 2, 4, 6'b000000);
    im[3]  = fr(0, 1, 3, 4, 6'b000010);
    im[4]  = fr(0, 1, 4, 4, 6'b000011);
    im[5]  = fi(6'b001000, 0, 5, 36);
    im[6]  = fr(5, 1, 6, 0, 6'b000100);
    im[7]  = fr(5, 1, 7, 0, 6'b000110);
    im[8]  = fr(5, 1, 8, 0, 6'b000111);
    im[9]  = fi(6'b101011, 0, 1, 0);
    im[10] = fi(6'b101011, 0, 2, 4);
    im[11] = fi(6'b101011, 0, 3, 8);
    im[12] = fi(6'b101011, 0, 4, 12);
    im[13] = fi(6'b101011, 0, 6, 16);
    im[14] = fi(6'b101011, 0, 7, 20);
    im[15] = fi(6'b101011, 0, 8, 24);
    im[16] = fj(16);
    start(40);
    chk("R6 upper then zero-extended or", dm[0], 32'h8765_F00F);
    chk("R7 sll", dm[1], 32'h765F_00F0);
    chk("R7 srl", dm[2], 32'h0876_5F00);
    chk("R7 sra", dm[3], 32'hF876_5F00);
    chk("R7 sllv uses rs[4:0]", dm[4], 32'h765F_00F0);
    chk("R7 srlv", dm[5], 32'h0876_5F00);
    chk("R7 srav", dm[6], 32'hF876_5F00);
  endtask

  task automatic t_mem();
    clear_mem();
    dm[14] = 32'h1234_5678;
    dm[16] = 32'hCAFE_F00D;
    im[0] = fi(6'b001000, 0, 1, 16'h30);
    im[1] = fi(6'b100011, 1, 2, 8);
    im[2] = fi(6'b001000, 0, 3, 16'h50);
    im[3] = fi(6'b101011, 3, 2, -4);
    im[4] = fi(6'b100011, 3, 4, -16);
    im[5] = fi(6'b101011, 3, 4, 4);
    im[6] = fj(6);
    start(20);
    chk("R8 load positive offset, store negative", dm[19], 32'h1234_5678);
    chk("R8 load negative offset", dm[21], 32'hCAFE_F00D);
  endtask

  task automatic t_misalign();
    clear_mem();
    im[0] = fi(6'b001000, 0, 1, 16'h51);
    im[1] = fi(6'b001000, 0, 2, 16'h55);
    im[2] = fi(6'b001000, 0, 3, 16'h77);
    im[3] = fi(6'b101011, 1, 2, -1);
    im[4] = fi(6'b101011, 1, 3, 0);
    im[5] = fi(6'b100011, 1, 3, 2);
    im[6] = fi(6'b101011, 0, 3, 16'h60);
    im[7] = fj(7);
    start(20);
    chk("R8 aligned store", dm[20], 32'h55);
    chk("R9 misaligned store dropped", dm[20], 32'h55);
    chk("R9 misaligned load keeps rt", dm[24], 32'h77);
    chk("R12 one misalign pulse each", 32'(mis_cnt), 32'd2);
    chk("R12 misalign pulse after its instruction", mis_pc, BASE + 32'h10);
  endtask

  task automatic t_overflow();
    clear_mem();
    im[0]  = fi(6'b001111, 0, 1, 16'h7FFF);
    im[1]  = fi(6'b001101, 1, 1, 16'hFFFF);
    im[2]  = fi(6'b001000, 0, 2, 16'h11);
    im[3]  = fi(6'b001000, 1, 2, 1);
    im[4]  = fi(6'b001000, 0, 4, 16'h22);
    im[5]  = fr(1, 1, 4, 0, 6'b100000);
    im[6]  = fi(6'b001000, 0, 3, 1);
    im[7]  = fi(6'b001111, 0, 6, 16'h8000);
    im[8]  = fi(6'b001000, 0, 5, 16'h33);
    im[9]  = fr(6, 3, 5, 0, 6'b100010);
    im[10] = fi(6'b001000, 1, 7, -1);
    im[11] = fi(6'b101011, 0, 2, 0);
    im[12] = fi(6'b101011, 0, 4, 4);
    im[13] = fi(6'b101011, 0, 5, 8);
    im[14] = fi(6'b101011, 0, 7, 12);
    im[15] = fj(15);
    start(30);
    chk("R5 addi overflow keeps rt", dm[0], 32'h11);
    chk("R5 add overflow keeps rd", dm[1], 32'h22);
    chk("R5 sub overflow keeps rd", dm[2], 32'h33);
    chk("R5 addi negative no overflow", dm[3], 32'h7FFF_FFFE);
    chk("R12 one overflow pulse each", 32'(ovf_cnt), 32'd3);
    chk("R12 overflow pulse after its instruction", ovf_pc, BASE + 32'h0C);
  endtask

  task automatic t_branch();
    clear_mem();
    im[0]  = fi(6'b001000, 0, 1, 4);
    im[1]  = fi(6'b001000, 0, 2, 4);
    im[2]  = fi(6'b001000, 0, 3, 0);
    im[3]  = fi(6'b000100, 1, 2, 1);
    im[4]  = fi(6'b001000, 0, 3, 16'h99);
    im[5]  = fi(6'b000101, 1, 2, 1);
    im[6]  = fi(6'b001000, 0, 4, 16'h55);
    im[7]  = fi(6'b001000, 0, 6, 3);
    im[8]  = fi(6'b001000, 0, 7, 0);
    im[9]  = fi(6'b001000, 6, 6, -1);
    im[10] = fi(6'b001000, 7, 7, 1);
    im[11] = fi(6'b000101, 6, 0, -3);
    im[12] = fi(6'b101011, 0, 3, 0);
    im[13] = fi(6'b101011, 0, 4, 4);
    im[14] = fi(6'b101011, 0, 7, 8);
    im[15] = fj(15);
    start(40);
    chk("R10 beq taken skips", dm[0], 32'h0);
    chk("R10 bne not taken falls through", dm[1], 32'h55);
    chk("R10 backward bne loop count", dm[2], 32'd3);
  endtask

  task automatic t_jump();
    clear_mem();
    im[0] = fi(6'b001000, 0, 1, 16'h11);
    im[1] = fj(3);
    im[2] = fi(6'b001000, 0, 1, 16'h22);
    im[3] = fi(6'b001111, 0, 2, 16'h0040);
    im[4] = fi(6'b001101, 2, 2, 16'h1C);
    im[5] = fr(2, 0, 0, 0, 6'b001000);
    im[6] = fi(6'b001000, 0, 1, 16'h33);
    im[7] = fi(6'b101011, 0, 1, 0);
    im[8] = fj(8);
    start(20);
    chk("R11 jump and register jump skip", dm[0], 32'h11);
    chk("R11 settles in self loop", imem_addr, BASE + 32'h20);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_imm_shift();
    t_mem();
    t_misalign();
    t_overflow();
    t_branch();
    t_jump();
    summary();
    $finish;
  end

endmodule